// File: doc/BRIEF.md
# Double-Width Merging Funnel Shifter

This block shifts a 64-bit source word left or right by an amount n and fills the vacated bit positions from a second word, the merge operand. Multi-word shift loops use it: each step shifts one limb and takes the neighbouring limb's bits into the freed positions. In right mode the block also returns the bits that fell off the low end. They sit left-justified in a second output word, ready to be merged into the next limb down.

The datapath is a left rotator followed by a mask generator and a merge stage. A right shift by n is a left rotate by (64 - n) mod 64, with a keep-mask of ones in the low (64 - n) positions. A left shift is a left rotate by n, with a keep-mask of ones in the high (64 - n) positions. Both directions use one merge equation: kept rotated bits OR merge-operand bits outside the mask. An overflow flag reports whether any bits were shifted out. It is reported only when the record-form control is set. All three results are registered once, so they appear one clock after the inputs.

Top module: `dwfs_top`

## Requirements
- R1: The shift amount n is the low 6 bits of `shift_amt`; bits 63:6 of `shift_amt` have no effect on any output.
- R2: With `dir_right` = 1, `result` equals the source shifted right by n, with its top n bit positions taken from the top n bits of `merge_op`.
- R3: With `dir_right` = 0, `result` equals the source shifted left by n, with its low n bit positions taken from the low n bits of `merge_op`.
- R4: With `dir_right` = 1, `spill` holds the low n bits of the source in its top n positions and zeros in the other (64 - n) positions.
- R5: With `dir_right` = 0, `spill` is all zeros.
- R6: With `record_en` = 1, `overflow` is 1 exactly when some shifted-out bit is 1. These are the low n source bits in right mode and the high n source bits in left mode.
- R7: With `record_en` = 0, `overflow` is 0 whatever the operands.
- R8: With n = 0, `result` equals the source, `spill` is zero and `overflow` is 0, in both directions.
- R9: Outputs update on the rising clock edge after the inputs are applied (one cycle of latency). A synchronous active-low reset clears `result`, `spill` and `overflow` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_right | input | 1 | Shift direction: 1 = right, 0 = left |
| record_en | input | 1 | Record-form select; enables the overflow report |
| src_word | input | 64 | Word to be shifted |
| shift_amt | input | 64 | Shift amount; only bits 5:0 are used |
| merge_op | input | 64 | Word supplying the vacated bit positions |
| result | output | 64 | Merged shift result |
| spill | output | 64 | Right mode: shifted-out bits, left-justified; left mode: zero |
| overflow | output | 1 | Shifted-out bits were nonzero (record form only) |

## Verification
The hardest cases to reach are the mask edges. At n = 0 the right-mode rotate amount wraps to zero and the mask must be all ones. At n = 63 a single bit survives the shift. A further case is right mode where n > 0 but every shifted-out bit happens to be zero, so `overflow` must stay low even though bits did move. The stimulus sweeps every n from 0 to 63 in both directions, with the record form on and off. It then adds source words whose low n bits (right mode) or high n bits (left mode) are cleared on purpose, and all-ones operands that light every mask boundary. Each shift amount carries random junk in its upper bits, so every vector also tests that those bits are ignored. Expected values come from a 128-bit concatenate-and-shift model.

// File: rtl/dwfs_pkg.sv
// dwfs_pkg
// Shared constants and types for the double-width merging funnel shifter.
// Assumes the word width is a power of two.
package dwfs_pkg;

    localparam int DWFS_DEFAULT_W = 64;

    // Shift direction as seen by the datapath
    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } shift_dir_e;

endpackage

// File: rtl/dwfs_rotator.sv
// dwfs_rotator
// Rotates a word left by a binary amount using log2(W) fixed stages.
// Stage s rotates by 2**s when rot bit s is set.
// Assumes W is a power of two and SHW = log2(W).
module dwfs_rotator #(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  logic [W-1:0]   din,
    input  logic [SHW-1:0] rot,
    output logic [W-1:0]   dout
);

    logic [W-1:0] stage [SHW+1];

    assign stage[0] = din;

    // One rotate stage for each bit of the rotate amount
    for (genvar s = 0; s < SHW; s++) begin : g_stage
        localparam int K = 2 ** s;
        assign stage[s+1] = rot[s] ? {stage[s][W-1-K:0], stage[s][W-1:W-K]}
                                   : stage[s];
    end

    assign dout = stage[SHW];

endmodule

// File: rtl/dwfs_mask_gen.sv
// dwfs_mask_gen
// Builds the keep-mask that selects rotated source bits.
// Right: ones in the low (W - n) positions. Left: ones in the high (W - n)
// positions. Each bit is one compare, so the logic depth stays flat.
// Assumes n < W.
module dwfs_mask_gen #(
    parameter int W   = 64,
    parameter int SHW = $clog2(W)
) (
    input  dwfs_pkg::shift_dir_e dir,
    input  logic [SHW-1:0]       n,
    output logic [W-1:0]         keep
);

    localparam logic [SHW:0] W_EXT = (SHW+1)'(W);

    // One compare per bit position
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam logic [SHW:0] I_EXT = (SHW+1)'(i);
        logic right_keep;
        logic left_keep;
        assign right_keep = ({1'b0, n} + I_EXT) < W_EXT;
        assign left_keep  = I_EXT >= {1'b0, n};
        assign keep[i] = (dir == dwfs_pkg::DIR_RIGHT) ? right_keep : left_keep;
    end

endmodule

// File: rtl/dwfs_merge.sv
// dwfs_merge
// Merges the rotated source with the merge operand through the keep-mask.
// It also separates the bits that were shifted out.
// Assumes keep comes from dwfs_mask_gen for the same direction and amount.
module dwfs_merge #(
    parameter int W = 64
) (
    input  dwfs_pkg::shift_dir_e dir,
    input  logic [W-1:0]         rotated,
    input  logic [W-1:0]         merge_op,
    input  logic [W-1:0]         keep,
    output logic [W-1:0]         merged,
    output logic [W-1:0]         spill,
    output logic                 spill_any
);

    logic [W-1:0] out_bits;

    // Same merge equation for both directions
    always_comb begin
        merged   = (rotated & keep) | (merge_op & ~keep);
        out_bits = rotated & ~keep;
    end

    // The spill word is only returned in right mode; the flag uses both
    always_comb begin
        spill     = (dir == dwfs_pkg::DIR_RIGHT) ? out_bits : '0;
        spill_any = |out_bits;
    end

endmodule

// File: rtl/dwfs_top.sv
// dwfs_top
// Double-width merging funnel shifter with registered outputs.
// Rotate, mask and merge in one combinational path, then one output register.
// Assumes W is a power of two. Only the low log2(W) bits of shift_amt are used.
module dwfs_top #(
    parameter int W = dwfs_pkg::DWFS_DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         dir_right,
    input  logic         record_en,
    input  logic [W-1:0] src_word,
    input  logic [W-1:0] shift_amt,
    input  logic [W-1:0] merge_op,
    output logic [W-1:0] result,
    output logic [W-1:0] spill,
    output logic         overflow
);

    localparam int SHW = $clog2(W);

    dwfs_pkg::shift_dir_e dir;
    logic [SHW-1:0]       n;
    logic [SHW-1:0]       rot_amt;
    logic [W-1:0]         rotated;
    logic [W-1:0]         keep;
    logic [W-1:0]         merged_d;
    logic [W-1:0]         spill_d;
    logic                 spill_any;
    logic                 unused_amt_hi;
    logic                 primed_q;

    // Decode direction and the shift amount; the upper amount bits are dropped
    always_comb begin
        dir           = dwfs_pkg::shift_dir_e'(dir_right);
        n             = shift_amt[SHW-1:0];
        unused_amt_hi = ^shift_amt[W-1:SHW];
        rot_amt       = (dir == dwfs_pkg::DIR_RIGHT) ? (SHW'(0) - n) : n;
    end

    dwfs_rotator #(.W(W), .SHW(SHW)) u_rot (
        .din  (src_word),
        .rot  (rot_amt),
        .dout (rotated)
    );

    dwfs_mask_gen #(.W(W), .SHW(SHW)) u_mask (
        .dir  (dir),
        .n    (n),
        .keep (keep)
    );

    dwfs_merge #(.W(W)) u_merge (
        .dir       (dir),
        .rotated   (rotated),
        .merge_op  (merge_op),
        .keep      (keep),
        .merged    (merged_d),
        .spill     (spill_d),
        .spill_any (spill_any)
    );

    // Output register with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result   <= '0;
            spill    <= '0;
            overflow <= 1'b0;
        end else begin
            result   <= merged_d;
            spill    <= spill_d;
            overflow <= record_en & spill_any;
        end
    end

    // Marks that the output register holds a computed value (used by checks)
    always_ff @(posedge clk) begin
        primed_q <= rst_n;
    end

    // R5: left mode never returns spilled bits
    p_left_spill_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(dir_right)) |-> (spill == '0));

    // R7: no overflow report outside the record form
    p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && !$past(record_en)) |-> !overflow);

    // R8: a zero shift passes the source through untouched
    p_zero_shift_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && ($past(shift_amt[SHW-1:0]) == '0))
            |-> (result == $past(src_word) && spill == '0 && !overflow));

    // R6: in right record form, overflow agrees with the spill word
    p_right_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(dir_right) && $past(record_en))
            |-> (overflow == (spill != '0)));

    // R4: spilled bits and the source bits kept in result never overlap
    p_spill_disjoint_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed_q && $past(dir_right))
            |-> ((spill & (result & ~$past(merge_op))) == '0
                 || $past(merge_op) == '1));

endmodule

// File: tb/dwfs_top_test.sv
// dwfs_top_test
// Scoreboard bench: the driver pushes expected values from a 128-bit
// concatenate-and-shift model; the monitor pops and compares them one cycle later.
module dwfs_top_test;

    localparam int W = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         dir_right = 1'b0;
    logic         record_en = 1'b0;
    logic [W-1:0] src_word = '0;
    logic [W-1:0] shift_amt = '0;
    logic [W-1:0] merge_op = '0;
    logic [W-1:0] result;
    logic [W-1:0] spill;
    logic         overflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [W-1:0] q_res [$];
    logic [W-1:0] q_spl [$];
    logic         q_ovf [$];
    string        q_tag [$];

    always #2 clk = ~clk;

    dwfs_top #(.W(W)) uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir_right (dir_right),
        .record_en (record_en),
        .src_word  (src_word),
        .shift_amt (shift_amt),
        .merge_op  (merge_op),
        .result    (result),
        .spill     (spill),
        .overflow  (overflow)
    );

    task automatic check64(string tag, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Driver: apply one vector at the falling edge and push its expected outputs
    task automatic drive(bit dr, bit rec, logic [5:0] n, logic [W-1:0] a, logic [W-1:0] c);
        logic [2*W-1:0] wide;
        logic [W-1:0]   e_res, e_spl, out_bits, ones;
        string          tag;
        @(negedge clk);
        dir_right = dr;
        record_en = rec;
        src_word  = a;
        merge_op  = c;
        shift_amt = {$urandom(), $urandom()};   // R1: junk in the upper bits
        shift_amt[5:0] = n;
        ones = '1;
        if (dr) begin
            wide     = {a, {W{1'b0}}} >> n;
            e_res    = wide[2*W-1:W] | (c & ~(ones >> n));
            out_bits = wide[W-1:0];
            e_spl    = out_bits;
            tag      = "R1 R2 R4";
        end else begin
            wide     = {{W{1'b0}}, a} << n;
            e_res    = wide[W-1:0] | (c & ~(ones << n));
            out_bits = wide[2*W-1:W];
            e_spl    = '0;
            tag      = "R1 R3 R5";
        end
        tag = {tag, rec ? " R6" : " R7", (n == 0) ? " R8" : ""};
        q_res.push_back(e_res);
        q_spl.push_back(e_spl);
        q_ovf.push_back(rec && (out_bits != '0));
        q_tag.push_back(tag);
    endtask

    // Monitor: just after each rising edge, compare against the oldest entry (R9 latency)
    always @(posedge clk) begin
        #1;
        if (rst_n && q_res.size() > 0) begin
            string t;
            t = q_tag.pop_front();
            check64(t, "result", result, q_res.pop_front());
            check64(t, "spill", spill, q_spl.pop_front());
            check64(t, "overflow", {63'b0, overflow}, {63'b0, q_ovf.pop_front()});
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        // R9: reset clears all outputs, even with live inputs
        src_word  = '1;
        merge_op  = '1;
        shift_amt = 64'd5;
        record_en = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check64("R9", "reset result", result, '0);
        check64("R9", "reset spill", spill, '0);
        check64("R9", "reset overflow", {63'b0, overflow}, '0);
        rst_n = 1'b1;

        // Full sweep of n, both directions, record form on and off
        for (int rec = 0; rec < 2; rec++) begin
            for (int n = 0; n < 64; n++) begin
                for (int dr = 0; dr < 2; dr++) begin
                    drive(dr[0], rec[0], n[5:0], {$urandom(), $urandom()}, {$urandom(), $urandom()});
                end
            end
        end

        // Shifted-out bits cleared on purpose: overflow must stay low (R6)
        for (int n = 1; n < 64; n += 7) begin
            logic [W-1:0] a;
            logic [W-1:0] ones;
            ones = '1;
            a = {$urandom(), $urandom()};
            drive(1'b1, 1'b1, n[5:0], a & ~(ones >> (W - n)), {$urandom(), $urandom()});
            drive(1'b0, 1'b1, n[5:0], a & (ones >> n), {$urandom(), $urandom()});
        end

        // All-ones and all-zeros operands at the mask edges (R2 R3 R4 R8)
        foreach (q_res[i]) ; // keep queue type referenced
        for (int k = 0; k < 4; k++) begin
            logic [5:0] n;
            n = (k == 0) ? 6'd0 : (k == 1) ? 6'd1 : (k == 2) ? 6'd32 : 6'd63;
            drive(1'b1, 1'b1, n, '1, '0);
            drive(1'b0, 1'b1, n, '1, '0);
            drive(1'b1, 1'b1, n, '0, '1);
            drive(1'b0, 1'b1, n, '0, '1);
        end

        // Drain the scoreboard
        repeat (4) @(posedge clk);
        #2;
        if (q_res.size() != 0) begin
            fails++;
            $display("FAIL R9 scoreboard not drained actual=%0d expected=0", q_res.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule